// File: doc/BRIEF.md
# Configurable Programmable-Logic Macrocell

This block is the storage and output stage of one cell in a sum-of-products logic array. A data value, chosen from the cell's OR-sum, a short bypass path or a direct pad input and passed through a programmable inverting XOR, feeds a storage element. Configuration selects whether that element is an edge-triggered D register, a level-sensitive D latch or a toggle flip-flop. It is clocked from one of four global clocks, a per-cell product-term clock or one of two shared product-term clocks. Global clocks 1 to 3 may be inverted; global clock 0 may not.

Registering is qualified by a clock enable rather than a gated clock. The element is cleared or set asynchronously by per-cell product terms, by two shared terms and by a global set/reset pin. Each cell decides whether that pin presets it, resets it or leaves it alone, and at which polarity the pin is active. The cell drives two outputs at once: the stored value and an unrelated combinatorial value taken from the XORed sum.

Top module: `cpld_macrocell`

## Requirements
- R1: With cfg_mode_i = 0 (or the spare code 3) the element is a D register that loads the data on a rising edge of the effective clock. With cfg_mode_i = 2 it is a toggle flip-flop that inverts on a rising edge when the data is 1 and holds when it is 0.
- R2: With cfg_mode_i = 1 the element is a D latch. It is transparent while the effective clock is high and the enable is true, and holds at all other times.
- R3: The enable is the AND of pt_clken_i, when cfg_ce_sel_i bit 0 is set, and gclken_i, when bit 1 is set. With both bits clear the enable is always true. While the enable is false no load, toggle or transparency occurs.
- R4: cfg_clk_sel_i picks the clock: codes 0 to 3 give gclk_i[0..3], 4 gives pt_clk_i, 5 and 6 give sh_clk_i[0] and sh_clk_i[1], and 7 gives a constant low clock that never updates the element.
- R5: cfg_clk_inv_i[n] inverts gclk_i[n] for n = 1..3, so the element is clocked on the falling pin edge and a latch is open while the pin is low. Bit 0 has no effect, and no bit affects the product-term clocks.
- R6: The data is the source picked by cfg_dsrc_i XORed with cfg_xor_i. The codes are 0 sum_i, 1 byp_i, 2 pad_i and 3 sum_i.
- R7: comb_o equals sum_i XOR cfg_xor_i at all times, whatever the storage mode, clock or stored value.
- R8: rst_ni low or pt_rst_i high clears reg_o, and pt_pre_i high sets it, without a clock. When a clear and a set are both active, the clear wins.
- R9: A shared term sh_rst_i[k] acts only when cfg_sh_mask_i[k] is set. Active shared terms set the element when cfg_sh_pre_i is 1 and clear it when it is 0.
- R10: gsr_i is active when it equals cfg_gsr_pol_i. Then cfg_gsr_mode_i = 1 clears the element, 2 sets it, and 0 or 3 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous clear of the element |
| sum_i | input | 1 | OR-sum of the cell's product terms |
| byp_i | input | 1 | Short bypass data path |
| pad_i | input | 1 | Direct pad input for input-register use |
| pt_clk_i | input | 1 | Per-cell product-term clock |
| pt_clken_i | input | 1 | Per-cell product-term clock enable |
| pt_rst_i | input | 1 | Per-cell product-term asynchronous clear |
| pt_pre_i | input | 1 | Per-cell product-term asynchronous set |
| sh_clk_i | input | NUM_SHCLK | Shared product-term clocks |
| sh_rst_i | input | NUM_SHRST | Shared product-term set/clear terms |
| gclk_i | input | NUM_GCLK | Global clocks |
| gclken_i | input | 1 | Global clock enable |
| gsr_i | input | 1 | Global set/reset pin |
| cfg_mode_i | input | 2 | Storage mode |
| cfg_xor_i | input | 1 | Data inversion |
| cfg_dsrc_i | input | 2 | Data source select |
| cfg_clk_sel_i | input | CLK_SEL_W | Clock source select |
| cfg_clk_inv_i | input | NUM_GCLK | Per-global-clock inversion |
| cfg_ce_sel_i | input | 2 | Enable source mask |
| cfg_sh_mask_i | input | NUM_SHRST | Shared term participation mask |
| cfg_sh_pre_i | input | 1 | Shared terms set (1) or clear (0) |
| cfg_gsr_mode_i | input | 2 | Global set/reset action |
| cfg_gsr_pol_i | input | 1 | Active level of gsr_i |
| reg_o | output | 1 | Stored value |
| comb_o | output | 1 | Combinatorial value |

## Verification
Two of the cell's functions can fall together: an asynchronous clear and an asynchronous set, and a clock edge with either of them. The bench holds pt_pre_i and pt_rst_i high at the same time and separately delivers a rising product-term clock while the clear is held. In both cases the stored value must stay 0. It is judged at the output between stimuli, and a property samples it again on every falling edge of global clock 0.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    MODE_DREG   = 2'd0,
    MODE_DLAT   = 2'd1,
    MODE_TOGGLE = 2'd2,
    MODE_SPARE  = 2'd3
  } store_mode_e;

  typedef enum logic [1:0] {
    DSRC_SUM   = 2'd0,
    DSRC_BYP   = 2'd1,
    DSRC_PAD   = 2'd2,
    DSRC_SPARE = 2'd3
  } dsrc_e;

  typedef enum logic [1:0] {
    GSR_OFF   = 2'd0,
    GSR_CLR   = 2'd1,
    GSR_SET   = 2'd2,
    GSR_SPARE = 2'd3
  } gsr_mode_e;
endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
  parameter int NUM_GCLK  = 4,
  parameter int NUM_SHCLK = 2,
  parameter int SEL_W     = 3
) (
  input  logic [NUM_GCLK-1:0]  gclk_i,
  input  logic [NUM_GCLK-1:0]  inv_i,
  input  logic                 pt_clk_i,
  input  logic [NUM_SHCLK-1:0] sh_clk_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 clk_o
);
  localparam int NUM_SRC = NUM_GCLK + 1 + NUM_SHCLK;
  localparam int PAD_W   = 1 << SEL_W;

  logic [NUM_SRC-1:0] src;
  logic [PAD_W-1:0]   src_pad;
  logic               unused_inv0;

  // global clock 0 is the low-skew master: never inverted
  assign unused_inv0 = inv_i[0];

  for (genvar g = 0; g < NUM_GCLK; g++) begin : g_gclk
    if (g == 0) begin : g_plain
      assign src[g] = gclk_i[g];
    end else begin : g_inv
      assign src[g] = gclk_i[g] ^ inv_i[g];
    end
  end

  assign src[NUM_GCLK] = pt_clk_i;

  for (genvar s = 0; s < NUM_SHCLK; s++) begin : g_shclk
    assign src[NUM_GCLK+1+s] = sh_clk_i[s];
  end

  // unused select codes read a tied-low line
  always_comb begin
    src_pad = '0;
    src_pad[NUM_SRC-1:0] = src;
  end

  assign clk_o = src_pad[sel_i];
endmodule

// File: rtl/mc_ctl.sv
module mc_ctl
  import mc_pkg::*;
#(
  parameter int NUM_SHRST = 2
) (
  input  logic                 rst_ni,
  input  logic                 pt_rst_i,
  input  logic                 pt_pre_i,
  input  logic [NUM_SHRST-1:0] sh_rst_i,
  input  logic [NUM_SHRST-1:0] sh_mask_i,
  input  logic                 sh_pre_i,
  input  logic                 gsr_i,
  input  logic                 gsr_pol_i,
  input  logic [1:0]           gsr_mode_i,
  input  logic                 pt_clken_i,
  input  logic                 gclken_i,
  input  logic [1:0]           ce_sel_i,
  output logic                 clr_o,
  output logic                 set_o,
  output logic                 en_o
);
  gsr_mode_e gsr_mode;
  logic      sh_hit;
  logic      gsr_act;
  logic      clr_req;
  logic      set_req;

  assign gsr_mode = gsr_mode_e'(gsr_mode_i);
  assign sh_hit   = |(sh_rst_i & sh_mask_i);
  assign gsr_act  = (gsr_i == gsr_pol_i);

  assign clr_req = !rst_ni || pt_rst_i || (sh_hit && !sh_pre_i) ||
                   (gsr_act && gsr_mode == GSR_CLR);
  assign set_req = pt_pre_i || (sh_hit && sh_pre_i) ||
                   (gsr_act && gsr_mode == GSR_SET);

  // clear dominates: set is withheld while any clear is active
  assign clr_o = clr_req;
  assign set_o = set_req && !clr_req;

  assign en_o = (!ce_sel_i[0] || pt_clken_i) && (!ce_sel_i[1] || gclken_i);
endmodule

// File: rtl/mc_dpath.sv
module mc_dpath
  import mc_pkg::*;
(
  input  logic       sum_i,
  input  logic       byp_i,
  input  logic       pad_i,
  input  logic       xor_i,
  input  logic [1:0] dsrc_i,
  output logic       d_o,
  output logic       comb_o
);
  logic raw;

  always_comb begin
    unique case (dsrc_e'(dsrc_i))
      DSRC_BYP: raw = byp_i;
      DSRC_PAD: raw = pad_i;
      default:  raw = sum_i;
    endcase
  end

  assign d_o    = raw ^ xor_i;
  assign comb_o = sum_i ^ xor_i;
endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
(
  input  logic       clk_i,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic       set_i,
  input  logic       d_i,
  input  logic [1:0] mode_i,
  output logic       q_o
);
  store_mode_e mode;
  logic        ff_q;
  logic        lat_q;

  assign mode = store_mode_e'(mode_i);

  always_ff @(posedge clk_i or posedge clr_i or posedge set_i) begin
    if (clr_i)      ff_q <= 1'b0;
    else if (set_i) ff_q <= 1'b1;
    else if (en_i)  ff_q <= (mode == MODE_TOGGLE) ? (ff_q ^ d_i) : d_i;
  end

  always_latch begin
    if (clr_i)                lat_q = 1'b0;
    else if (set_i)           lat_q = 1'b1;
    else if (clk_i && en_i)   lat_q = d_i;
  end

  assign q_o = (mode == MODE_DLAT) ? lat_q : ff_q;
endmodule

// File: rtl/cpld_macrocell.sv
module cpld_macrocell #(
  parameter int NUM_GCLK  = 4,
  parameter int NUM_SHCLK = 2,
  parameter int NUM_SHRST = 2,
  parameter int CLK_SEL_W = $clog2(NUM_GCLK + 1 + NUM_SHCLK)
) (
  input  logic                 rst_ni,
  input  logic                 sum_i,
  input  logic                 byp_i,
  input  logic                 pad_i,
  input  logic                 pt_clk_i,
  input  logic                 pt_clken_i,
  input  logic                 pt_rst_i,
  input  logic                 pt_pre_i,
  input  logic [NUM_SHCLK-1:0] sh_clk_i,
  input  logic [NUM_SHRST-1:0] sh_rst_i,
  input  logic [NUM_GCLK-1:0]  gclk_i,
  input  logic                 gclken_i,
  input  logic                 gsr_i,
  input  logic [1:0]           cfg_mode_i,
  input  logic                 cfg_xor_i,
  input  logic [1:0]           cfg_dsrc_i,
  input  logic [CLK_SEL_W-1:0] cfg_clk_sel_i,
  input  logic [NUM_GCLK-1:0]  cfg_clk_inv_i,
  input  logic [1:0]           cfg_ce_sel_i,
  input  logic [NUM_SHRST-1:0] cfg_sh_mask_i,
  input  logic                 cfg_sh_pre_i,
  input  logic [1:0]           cfg_gsr_mode_i,
  input  logic                 cfg_gsr_pol_i,
  output logic                 reg_o,
  output logic                 comb_o
);
  logic clk_eff;
  logic clr;
  logic set;
  logic en;
  logic d;

  mc_clk_sel #(
    .NUM_GCLK (NUM_GCLK),
    .NUM_SHCLK(NUM_SHCLK),
    .SEL_W    (CLK_SEL_W)
  ) u_clk_sel (
    .gclk_i  (gclk_i),
    .inv_i   (cfg_clk_inv_i),
    .pt_clk_i(pt_clk_i),
    .sh_clk_i(sh_clk_i),
    .sel_i   (cfg_clk_sel_i),
    .clk_o   (clk_eff)
  );

  mc_ctl #(
    .NUM_SHRST(NUM_SHRST)
  ) u_ctl (
    .rst_ni    (rst_ni),
    .pt_rst_i  (pt_rst_i),
    .pt_pre_i  (pt_pre_i),
    .sh_rst_i  (sh_rst_i),
    .sh_mask_i (cfg_sh_mask_i),
    .sh_pre_i  (cfg_sh_pre_i),
    .gsr_i     (gsr_i),
    .gsr_pol_i (cfg_gsr_pol_i),
    .gsr_mode_i(cfg_gsr_mode_i),
    .pt_clken_i(pt_clken_i),
    .gclken_i  (gclken_i),
    .ce_sel_i  (cfg_ce_sel_i),
    .clr_o     (clr),
    .set_o     (set),
    .en_o      (en)
  );

  mc_dpath u_dpath (
    .sum_i (sum_i),
    .byp_i (byp_i),
    .pad_i (pad_i),
    .xor_i (cfg_xor_i),
    .dsrc_i(cfg_dsrc_i),
    .d_o   (d),
    .comb_o(comb_o)
  );

  mc_store u_store (
    .clk_i (clk_eff),
    .en_i  (en),
    .clr_i (clr),
    .set_i (set),
    .d_i   (d),
    .mode_i(cfg_mode_i),
    .q_o   (reg_o)
  );
endmodule

// File: rtl/cpld_macrocell_chk.sv
module cpld_macrocell_chk #(
  parameter int NUM_GCLK  = 4,
  parameter int NUM_SHCLK = 2,
  parameter int NUM_SHRST = 2,
  parameter int CLK_SEL_W = 3
) (
  input logic                 rst_ni,
  input logic                 sum_i,
  input logic                 byp_i,
  input logic                 pad_i,
  input logic                 pt_clk_i,
  input logic                 pt_clken_i,
  input logic                 pt_rst_i,
  input logic                 pt_pre_i,
  input logic [NUM_SHCLK-1:0] sh_clk_i,
  input logic [NUM_SHRST-1:0] sh_rst_i,
  input logic [NUM_GCLK-1:0]  gclk_i,
  input logic                 gclken_i,
  input logic                 gsr_i,
  input logic [1:0]           cfg_mode_i,
  input logic                 cfg_xor_i,
  input logic [1:0]           cfg_dsrc_i,
  input logic [CLK_SEL_W-1:0] cfg_clk_sel_i,
  input logic [NUM_GCLK-1:0]  cfg_clk_inv_i,
  input logic [1:0]           cfg_ce_sel_i,
  input logic [NUM_SHRST-1:0] cfg_sh_mask_i,
  input logic                 cfg_sh_pre_i,
  input logic [1:0]           cfg_gsr_mode_i,
  input logic                 cfg_gsr_pol_i,
  input logic                 reg_o,
  input logic                 comb_o
);
  logic sh_clr;
  logic sh_set;
  logic gsr_on;

  assign sh_clr = (|(sh_rst_i & cfg_sh_mask_i)) && !cfg_sh_pre_i;
  assign sh_set = (|(sh_rst_i & cfg_sh_mask_i)) && cfg_sh_pre_i;
  assign gsr_on = (gsr_i == cfg_gsr_pol_i);

  p_reset_wins_r8: assert property (@(negedge gclk_i[0]) disable iff (!rst_ni)
    pt_rst_i |-> !reg_o);

  p_pt_preset_r8: assert property (@(negedge gclk_i[0]) disable iff (!rst_ni)
    (pt_pre_i && !pt_rst_i && !sh_clr && !(gsr_on && cfg_gsr_mode_i == 2'd1)) |-> reg_o);

  p_comb_indep_r7: assert property (@(negedge gclk_i[0]) disable iff (!rst_ni)
    ($stable(sum_i) && $stable(cfg_xor_i)) |-> $stable(comb_o));

  p_gsr_reset_r10: assert property (@(negedge gclk_i[0]) disable iff (!rst_ni)
    (gsr_on && cfg_gsr_mode_i == 2'd1) |-> !reg_o);

  p_gsr_preset_r10: assert property (@(negedge gclk_i[0]) disable iff (!rst_ni)
    (gsr_on && cfg_gsr_mode_i == 2'd2 && !pt_rst_i && !sh_clr) |-> reg_o);

  p_shared_set_r9: assert property (@(negedge gclk_i[0]) disable iff (!rst_ni)
    (sh_set && !pt_rst_i && !(gsr_on && cfg_gsr_mode_i == 2'd1)) |-> reg_o);
endmodule

bind cpld_macrocell cpld_macrocell_chk #(
  .NUM_GCLK (NUM_GCLK),
  .NUM_SHCLK(NUM_SHCLK),
  .NUM_SHRST(NUM_SHRST),
  .CLK_SEL_W(CLK_SEL_W)
) u_chk (.*);

// File: tb/cpld_macrocell_tb.sv
module cpld_macrocell_tb;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       sum_i, byp_i, pad_i;
  logic       pt_clk, pt_clken, pt_rst, pt_pre;
  logic [1:0] sh_clk, sh_rst;
  logic [3:0] gclk;
  logic       gclken, gsr;
  logic [1:0] cfg_mode;
  logic       cfg_xor;
  logic [1:0] cfg_dsrc;
  logic [2:0] cfg_clk_sel;
  logic [3:0] cfg_clk_inv;
  logic [1:0] cfg_ce_sel;
  logic [1:0] cfg_sh_mask;
  logic       cfg_sh_pre;
  logic [1:0] cfg_gsr_mode;
  logic       cfg_gsr_pol;
  logic       reg_o, comb_o;

  int n_chk  = 0;
  int n_fail = 0;
  int n_vec  = 0;

  always #2 clk = ~clk;

  cpld_macrocell u_dut (
    .rst_ni        (rst_ni),
    .sum_i         (sum_i),
    .byp_i         (byp_i),
    .pad_i         (pad_i),
    .pt_clk_i      (pt_clk),
    .pt_clken_i    (pt_clken),
    .pt_rst_i      (pt_rst),
    .pt_pre_i      (pt_pre),
    .sh_clk_i      (sh_clk),
    .sh_rst_i      (sh_rst),
    .gclk_i        (gclk),
    .gclken_i      (gclken),
    .gsr_i         (gsr),
    .cfg_mode_i    (cfg_mode),
    .cfg_xor_i     (cfg_xor),
    .cfg_dsrc_i    (cfg_dsrc),
    .cfg_clk_sel_i (cfg_clk_sel),
    .cfg_clk_inv_i (cfg_clk_inv),
    .cfg_ce_sel_i  (cfg_ce_sel),
    .cfg_sh_mask_i (cfg_sh_mask),
    .cfg_sh_pre_i  (cfg_sh_pre),
    .cfg_gsr_mode_i(cfg_gsr_mode),
    .cfg_gsr_pol_i (cfg_gsr_pol),
    .reg_o         (reg_o),
    .comb_o        (comb_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(logic act, logic exp, string req, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic set_pin(int s, logic val);
    if (s < 4)       gclk[s] = val;
    else if (s == 4) pt_clk = val;
    else if (s < 7)  sh_clk[s-5] = val;
  endtask

  task automatic init_q(logic b);
    if (b) pt_pre = 1'b1; else pt_rst = 1'b1;
    tick();
    pt_pre = 1'b0;
    pt_rst = 1'b0;
    tick();
  endtask

  task automatic gpulse();
    gclk[0] = 1'b1; tick();
    gclk[0] = 1'b0; tick();
  endtask

  function automatic logic upd(logic qq, int m, logic de);
    return (m == 2) ? (qq ^ de) : de;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    rst_ni = 1'b0;
    {sum_i, byp_i, pad_i} = '0;
    {pt_clk, pt_clken, pt_rst, pt_pre} = '0;
    sh_clk = '0; sh_rst = '0; gclk = '0;
    gclken = 1'b1; gsr = 1'b0;
    cfg_mode = 2'd0; cfg_xor = 1'b0; cfg_dsrc = 2'd0;
    cfg_clk_sel = 3'd4; cfg_clk_inv = '0; cfg_ce_sel = 2'd3;
    cfg_sh_mask = '0; cfg_sh_pre = 1'b0;
    cfg_gsr_mode = 2'd0; cfg_gsr_pol = 1'b1;
    repeat (3) tick();
    chk(reg_o, 1'b0, "R8", "reset state");
    rst_ni = 1'b1;
    tick();
    chk(reg_o, 1'b0, "R8", "after reset release");

    // sweep: clock source x inversion x mode x xor x data source x value
    for (int s = 0; s < 8; s++)
      for (int iv = 0; iv < 2; iv++)
        for (int m = 0; m < 4; m++)
          for (int x = 0; x < 2; x++)
            for (int ds = 0; ds < 4; ds++)
              for (int v = 0; v < 2; v++) begin
                logic q, de, einv, dead, q0;
                string ctx;
                n_vec++;
                pt_clken = 1'b0;
                cfg_clk_sel = 3'(s);
                cfg_clk_inv = iv[0] ? 4'hF : 4'h0;
                cfg_mode = 2'(m);
                cfg_xor = x[0];
                cfg_dsrc = 2'(ds);
                sum_i = ~v[0]; byp_i = ~v[0]; pad_i = ~v[0];
                case (ds)
                  1: byp_i = v[0];
                  2: pad_i = v[0];
                  default: sum_i = v[0];
                endcase
                tick();
                q0 = n_vec[1];
                init_q(q0);
                q = q0;
                ctx = $sformatf("src=%0d inv=%0d mode=%0d xor=%0d dsrc=%0d v=%0d", s, iv, m, x, ds, v);
                chk(reg_o, q, "R8", {"init ", ctx});
                chk(comb_o, sum_i ^ x[0], "R7", ctx);
                de = v[0] ^ x[0];
                einv = iv[0] && (s >= 1) && (s <= 3);
                dead = (s == 7);
                pt_clken = 1'b1;
                tick();
                if (m == 1 && einv) q = de;
                chk(reg_o, q, "R2", {"enable idle ", ctx});
                set_pin(s, 1'b1);
                tick();
                if (!dead && !einv) q = upd(q, m, de);
                chk(reg_o, q, (m == 1) ? "R2" : ((m == 2) ? "R1" : "R6"), {"pin high ", ctx});
                set_pin(s, 1'b0);
                tick();
                if (!dead && einv) q = upd(q, m, de);
                chk(reg_o, q, einv ? "R5" : "R4", {"pin low ", ctx});
                chk(comb_o, sum_i ^ x[0], "R7", {"after clock ", ctx});
                pt_clken = 1'b0;
                tick();
              end

    // R3: enable masking, register and latch
    cfg_clk_sel = 3'd4; cfg_clk_inv = '0; cfg_xor = 1'b0; cfg_dsrc = 2'd0;
    sum_i = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int ce = 0; ce < 4; ce++)
        for (int pe = 0; pe < 2; pe++)
          for (int ge = 0; ge < 2; ge++) begin
            logic en;
            cfg_mode = 2'(m);
            cfg_ce_sel = 2'(ce);
            pt_clken = pe[0];
            gclken = ge[0];
            tick();
            init_q(1'b0);
            en = (!ce[0] || pe[0]) && (!ce[1] || ge[0]);
            pt_clk = 1'b1;
            tick();
            chk(reg_o, en, "R3", $sformatf("mode=%0d ce_sel=%0d ptce=%0d gce=%0d", m, ce, pe, ge));
            pt_clk = 1'b0;
            tick();
          end
    cfg_ce_sel = 2'd3; pt_clken = 1'b0; gclken = 1'b1; cfg_mode = 2'd0;
    tick();

    // R8: set, reset, both at once, clock during reset
    pt_pre = 1'b1; gpulse();
    chk(reg_o, 1'b1, "R8", "pt preset");
    pt_rst = 1'b1; gpulse();
    chk(reg_o, 1'b0, "R8", "reset wins over preset");
    pt_pre = 1'b0; pt_rst = 1'b0; gpulse();
    chk(reg_o, 1'b0, "R8", "hold after release");
    pt_rst = 1'b1; pt_clken = 1'b1; sum_i = 1'b1;
    pt_clk = 1'b1; tick();
    chk(reg_o, 1'b0, "R8", "clock edge under reset");
    pt_clk = 1'b0; tick();
    pt_rst = 1'b0; pt_clken = 1'b0; tick();
    init_q(1'b1);
    rst_ni = 1'b0; tick();
    chk(reg_o, 1'b0, "R8", "rst_ni clears");
    rst_ni = 1'b1; tick();

    // R9: shared terms
    for (int mk = 0; mk < 4; mk++)
      for (int pr = 0; pr < 2; pr++)
        for (int k = 0; k < 2; k++) begin
          logic q0;
          cfg_sh_mask = 2'(mk);
          cfg_sh_pre = pr[0];
          q0 = ~pr[0];
          tick();
          init_q(q0);
          sh_rst[k] = 1'b1;
          tick();
          gpulse();
          chk(reg_o, mk[k] ? pr[0] : q0, "R9", $sformatf("mask=%0d pre=%0d term=%0d", mk, pr, k));
          sh_rst[k] = 1'b0;
          tick();
        end
    cfg_sh_mask = '0;

    // R10: global set/reset modes and polarity
    for (int p = 0; p < 2; p++)
      for (int gm = 0; gm < 4; gm++)
        for (int a = 0; a < 2; a++) begin
          logic q0, exp;
          cfg_gsr_mode = 2'(gm);
          cfg_gsr_pol = p[0];
          gsr = ~p[0];
          tick();
          q0 = (gm == 2) ? 1'b0 : ((gm == 1) ? 1'b1 : a[0]);
          init_q(q0);
          gsr = a[0] ? p[0] : ~p[0];
          tick();
          gpulse();
          exp = q0;
          if (a[0] && gm == 1) exp = 1'b0;
          if (a[0] && gm == 2) exp = 1'b1;
          chk(reg_o, exp, "R10", $sformatf("pol=%0d mode=%0d active=%0d", p, gm, a));
          gsr = ~p[0];
          tick();
        end
    cfg_gsr_mode = 2'd0; cfg_gsr_pol = 1'b1; gsr = 1'b0;
    tick();

    summary();
  end
endmodule